// File: doc/BRIEF.md
# Folded 9/7 Wavelet Lifting Engine

This block applies one level of the forward 9/7 biorthogonal wavelet to a stream of signed samples, one frame at a time, using fixed-point arithmetic. A frame of `FRAME_LEN` samples is taken in over a valid/ready input port and split into an even half and an odd half. A single shared multiply-add element is then reused for all four lifting steps. A 2-bit step counter selects the coefficient and the operand routing. In order, the steps are predict 1, update 1, predict 2 and update 2. Each step is applied to every even/odd pair before the next step starts. Every result is written back in place, so each step reads the previous step's results. At both frame edges the signal is extended by whole-sample mirroring.

After the last step, the frame is sent out as `FRAME_LEN/2` pairs. Each pair holds a normalised low-pass coefficient and a normalised high-pass coefficient. The low-pass value is multiplied by K ≈ 1.1496044 and the high-pass value by 1/K. The output port follows valid/ready rules. `out_valid` stays high and both data words hold steady until the cycle in which `out_ready` is also high. `in_ready` is high only while a frame is being collected, so the source is back-pressured during computation and output. The block takes one frame at a time.

Top module: `dwt97_fold`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A sample is taken only in a cycle where both `in_valid` and `in_ready` are 1. After `FRAME_LEN` samples are taken, `in_ready` stays 0 until the last output pair of that frame has been taken. `in_ready` and `out_valid` are never both 1.
- R3: The four lifting steps run in the order 0,1,2,3, one pair per cycle. `out_valid` first rises exactly `4*FRAME_LEN/2` clock edges after the edge that took the last sample.
- R4: Output pair p (p = 0 first) carries the low-pass value on `out_lo` and the high-pass value on `out_hi`. Each value lies within 3 LSB of the real-valued result. That result is computed as follows, with even samples e[p]=x[2p] and odd samples o[p]=x[2p+1]. o += a·(e[p]+e[p+1]); e += b·(o[p-1]+o[p]); o += c·(e[p]+e[p+1]); e += d·(o[p-1]+o[p]). The coefficients are a=-1.586134342, b=-0.05298011854, c=0.8829110762 and d=0.4435068522. Finally low = e·K and high = o/K, each rounded to the nearest integer.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, with `out_lo` and `out_hi` unchanged.
- R6: Frame edges use symmetric extension. A missing e[M] is taken as e[M-1], and a missing o[-1] as o[0]. As a result, a constant frame gives every high-pass output within 1 LSB of 0, including the first and last pairs.
- R7: Frames are independent. A frame sent right after another one gives the same outputs as if it had been sent alone.
- R8: `in_valid` and `in_data` have no effect while `in_ready` is 0. Samples offered during computation or output are not taken, and they do not change the outputs.
- R9: Across the full signed `DATA_W`-bit input range, no intermediate or output value overflows its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block is collecting a frame |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output pair offered |
| out_ready | input | 1 | Sink takes the output pair |
| out_lo | output | DATA_W+HEAD | Signed normalised low-pass coefficient |
| out_hi | output | DATA_W+HEAD | Signed normalised high-pass coefficient |

## Verification
The overflow assertions in the multiply-add element and the scaler rely on two assumptions about the inputs. Every input is a legal signed `DATA_W`-bit value, and the default headroom is at least as large as the worst-case growth of the 9/7 steps. The stimulus therefore stays within that range but deliberately includes full-scale alternating frames. The hold assertion on the output port assumes nothing about `out_ready`. For that reason, the bench drops `out_ready` for several cycles in the middle of a frame. It also holds `in_valid` high with unrelated data throughout a busy period.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;
  localparam int CW = 16;
  localparam int FB = 14;

  localparam logic signed [CW-1:0] K_A    = -16'sd25987;
  localparam logic signed [CW-1:0] K_B    = -16'sd868;
  localparam logic signed [CW-1:0] K_C    = 16'sd14466;
  localparam logic signed [CW-1:0] K_D    = 16'sd7266;
  localparam logic signed [CW-1:0] K_NORM = 16'sd18835;
  localparam logic signed [CW-1:0] K_INV  = 16'sd14252;

  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_EMIT} phase_t;

  function automatic logic signed [CW-1:0] step_coef(input logic [1:0] s);
    case (s)
      2'd0:    return K_A;
      2'd1:    return K_B;
      2'd2:    return K_C;
      default: return K_D;
    endcase
  endfunction
endpackage

// File: rtl/lift_pe.sv
module lift_pe
  import dwt97_pkg::*;
#(
  parameter int IW = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [IW-1:0] base,
  input  logic signed [IW-1:0] lft,
  input  logic signed [IW-1:0] rgt,
  input  logic signed [CW-1:0] coef,
  output logic signed [IW-1:0] res
);
  localparam int PW = IW + CW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FB - 1);

  logic signed [IW:0]   pair_sum;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_r;
  logic signed [PW:0]   res_w;

  assign pair_sum = lft + rgt;
  assign prod     = pair_sum * coef;
  assign prod_r   = (prod + HALF) >>> FB;
  assign res_w    = base + prod_r;
  assign res      = res_w[IW-1:0];

  AST_PE_FIT: assert property (@(posedge clk) disable iff (rst)
    en |-> (res_w[PW:IW-1] == '0 || res_w[PW:IW-1] == '1)); // R9
endmodule

// File: rtl/lift_sched.sv
module lift_sched
  import dwt97_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_fire,
  input  logic                   out_fire,
  output phase_t                 ph,
  output logic [1:0]             step,
  output logic [$clog2(N)-1:0]   cnt
);
  localparam int M  = N / 2;
  localparam int NW = $clog2(N);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_LOAD;
      step <= 2'd0;
      cnt  <= '0;
    end else begin
      case (ph)
        PH_LOAD: if (in_fire) begin
          if (cnt == NW'(N - 1)) begin
            cnt  <= '0;
            step <= 2'd0;
            ph   <= PH_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUN: begin
          if (cnt == NW'(M - 1)) begin
            cnt <= '0;
            if (step == 2'd3) ph <= PH_EMIT;
            else              step <= step + 2'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_EMIT: if (out_fire) begin
          if (cnt == NW'(M - 1)) begin
            cnt <= '0;
            ph  <= PH_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_LOAD;
      endcase
    end
  end

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RUN && cnt != NW'(M - 1)) |=> $stable(step)); // R3
  AST_EMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(ph == PH_EMIT) |-> $past(step) == 2'd3); // R3
  AST_LOAD_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LOAD && !in_fire) |=> ph == PH_LOAD); // R8
endmodule

// File: rtl/out_scale.sv
module out_scale
  import dwt97_pkg::*;
#(
  parameter int IW = 21,
  parameter int OW = 16,
  parameter int G  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [IW-1:0] lo_in,
  input  logic signed [IW-1:0] hi_in,
  output logic signed [OW-1:0] lo_out,
  output logic signed [OW-1:0] hi_out
);
  localparam int PW = IW + CW;
  localparam int SH = FB + G;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);

  logic signed [IW-1:0] lane_in  [2];
  logic signed [OW-1:0] lane_out [2];

  assign lane_in[0] = lo_in;
  assign lane_in[1] = hi_in;
  assign lo_out     = lane_out[0];
  assign hi_out     = lane_out[1];

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    localparam logic signed [CW-1:0] GAIN = (ln == 0) ? K_NORM : K_INV;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] res_w;
    assign prod  = lane_in[ln] * GAIN;
    assign res_w = (prod + HALF) >>> SH;
    assign lane_out[ln] = res_w[OW-1:0];

    AST_SCALE_FIT: assert property (@(posedge clk) disable iff (rst)
      en |-> (res_w[PW-1:OW-1] == '0 || res_w[PW-1:OW-1] == '1)); // R9
  end
endmodule

// File: rtl/dwt97_fold.sv
module dwt97_fold
  import dwt97_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int FRAME_LEN = 16,
  parameter int GUARD     = 4,
  parameter int HEAD      = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic signed [DATA_W-1:0]       in_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic signed [DATA_W+HEAD-1:0]  out_lo,
  output logic signed [DATA_W+HEAD-1:0]  out_hi
);
  localparam int M  = FRAME_LEN / 2;
  localparam int NW = $clog2(FRAME_LEN);
  localparam int PI = NW - 1;
  localparam int OW = DATA_W + HEAD;
  localparam int IW = OW + GUARD + 1;

  phase_t         ph;
  logic [1:0]     step;
  logic [NW-1:0]  cnt;
  logic           in_fire;
  logic           out_fire;
  logic           run_en;

  logic signed [IW-1:0] ev [M];
  logic signed [IW-1:0] od [M];

  logic [PI-1:0]         pidx;
  logic [PI-1:0]         pnx;
  logic [PI-1:0]         ppv;
  logic signed [IW-1:0]  ld_ext;
  logic signed [IW-1:0]  pe_base;
  logic signed [IW-1:0]  pe_lft;
  logic signed [IW-1:0]  pe_rgt;
  logic signed [IW-1:0]  pe_res;
  logic signed [CW-1:0]  pe_coef;

  assign in_ready  = (ph == PH_LOAD);
  assign out_valid = (ph == PH_EMIT);
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign run_en    = (ph == PH_RUN);

  lift_sched #(.N(FRAME_LEN)) u_sched (
    .clk(clk), .rst(rst), .in_fire(in_fire), .out_fire(out_fire),
    .ph(ph), .step(step), .cnt(cnt)
  );

  assign pidx = (ph == PH_LOAD) ? cnt[NW-1:1] : cnt[PI-1:0];
  assign pnx  = (pidx == PI'(M - 1)) ? pidx : pidx + 1'b1;
  assign ppv  = (pidx == '0) ? pidx : pidx - 1'b1;

  // Predict steps (even step code) refine an odd word from its even neighbours;
  // update steps refine an even word from its odd neighbours. Edge indices mirror.
  always_comb begin
    if (step[0] == 1'b0) begin
      pe_base = od[pidx];
      pe_lft  = ev[pidx];
      pe_rgt  = ev[pnx];
    end else begin
      pe_base = ev[pidx];
      pe_lft  = od[ppv];
      pe_rgt  = od[pidx];
    end
  end

  assign pe_coef = step_coef(step);
  assign ld_ext  = IW'(in_data) <<< GUARD;

  lift_pe #(.IW(IW)) u_pe (
    .clk(clk), .rst(rst), .en(run_en),
    .base(pe_base), .lft(pe_lft), .rgt(pe_rgt), .coef(pe_coef), .res(pe_res)
  );

  always_ff @(posedge clk) begin
    if (in_fire) begin
      if (cnt[0] == 1'b0) ev[pidx] <= ld_ext;
      else                od[pidx] <= ld_ext;
    end else if (run_en) begin
      if (step[0] == 1'b0) od[pidx] <= pe_res;
      else                 ev[pidx] <= pe_res;
    end
  end

  out_scale #(.IW(IW), .OW(OW), .G(GUARD)) u_scale (
    .clk(clk), .rst(rst), .en(out_valid),
    .lo_in(ev[pidx]), .hi_in(od[pidx]),
    .lo_out(out_lo), .hi_out(out_hi)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi))); // R5
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid)); // R2
  AST_BUSY_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    (in_fire && cnt == NW'(FRAME_LEN - 1)) |=> !in_ready); // R2
endmodule

// File: tb/dwt97_fold_test.sv
module dwt97_fold_test;
  localparam int W   = 12;
  localparam int N   = 16;
  localparam int M   = N / 2;
  localparam int OW  = W + 4;
  localparam real CA = -1.586134342;
  localparam real CB = -0.05298011854;
  localparam real CC = 0.8829110762;
  localparam real CD = 0.4435068522;
  localparam real KN = 1.149604398;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_ready;
  logic signed [W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 0;
  logic signed [OW-1:0] out_lo;
  logic signed [OW-1:0] out_hi;

  int total = 0;
  int bad = 0;
  int frm [N];
  int exp_lo [M];
  int exp_hi [M];
  int got_lo [M];
  int got_hi [M];

  always #2 clk = ~clk;

  dwt97_fold uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi)
  );

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL R3 watchdog expired: actual=%0d expected<=%0d cycles", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int diff = act - exp;
    total++;
    if (diff > tol || diff < -tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  task automatic ref_calc();
    real e [M];
    real o [M];
    real cf;
    for (int p = 0; p < M; p++) begin
      e[p] = frm[2*p];
      o[p] = frm[2*p+1];
    end
    for (int s = 0; s < 4; s++) begin
      cf = (s == 0) ? CA : (s == 1) ? CB : (s == 2) ? CC : CD;
      for (int p = 0; p < M; p++) begin
        if (s % 2 == 0) o[p] = o[p] + cf * (e[p] + e[(p == M-1) ? p : p+1]);
        else            e[p] = e[p] + cf * (o[(p == 0) ? 0 : p-1] + o[p]);
      end
    end
    for (int p = 0; p < M; p++) begin
      exp_lo[p] = rnd(e[p] * KN);
      exp_hi[p] = rnd(o[p] / KN);
    end
  endtask

  task automatic push_frame(output int lat);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_data  = W'(frm[i]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    lat = 0;
    @(negedge clk);
    in_valid = 0;
    while (!out_valid && lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic pull_frame(input bit bp);
    for (int p = 0; p < M; p++) begin
      if (bp) begin
        out_ready = 0;
        got_lo[p] = out_lo;
        got_hi[p] = out_hi;
        @(negedge clk);
        @(negedge clk);
        chk("R5 valid held", int'(out_valid), 1, 0);
        chk("R5 lo stable", int'(out_lo), got_lo[p], 0);
        chk("R5 hi stable", int'(out_hi), got_hi[p], 0);
      end
      out_ready = 1;
      while (!out_valid) @(negedge clk);
      got_lo[p] = out_lo;
      got_hi[p] = out_hi;
      @(negedge clk);
    end
    out_ready = 0;
  endtask

  task automatic run_frame(input string tag, input bit bp);
    int lat;
    ref_calc();
    push_frame(lat);
    chk({tag, " R3 latency"}, lat, 4*M, 0);
    chk({tag, " R2 busy"}, int'(in_ready), 0, 0);
    pull_frame(bp);
    for (int p = 0; p < M; p++) begin
      chk({tag, " R4 low"}, got_lo[p], exp_lo[p], 3);
      chk({tag, " R4 high"}, got_hi[p], exp_hi[p], 3);
    end
    chk({tag, " R2 ready again"}, int'(in_ready), 1, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 in_ready", int'(in_ready), 1, 0);
    chk("R1 out_valid", int'(out_valid), 0, 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < N; i++) frm[i] = i * 100 - 700;
    run_frame("ramp", 0);
  endtask

  task automatic t_impulse();
    for (int i = 0; i < N; i++) frm[i] = (i == 0 || i == 7) ? 1500 : 0;
    run_frame("impulse", 0);
  endtask

  task automatic t_constant();
    for (int i = 0; i < N; i++) frm[i] = 1000;
    run_frame("const", 0);
    for (int p = 0; p < M; p++) chk("R6 flat high", got_hi[p], 0, 1);
  endtask

  task automatic t_extremes();
    for (int i = 0; i < N; i++) frm[i] = (i % 2 == 0) ? 2047 : -2048;
    run_frame("extreme R9", 0);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < N; i++) frm[i] = ((i * 37 + 11) % 97) * 40 - 1900;
    run_frame("bp", 1);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < N; i++) frm[i] = 2047 - i * 250;
    run_frame("R7 first", 0);
    for (int i = 0; i < N; i++) frm[i] = ((i * 53 + 5) % 61) * 60 - 1800;
    run_frame("R7 second", 0);
  endtask

  task automatic t_ignore_busy();
    int lat;
    for (int i = 0; i < N; i++) frm[i] = (i % 3) * 500 - 400;
    ref_calc();
    push_frame(lat);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1;
      in_data  = W'(k * 411 - 999);
      out_ready = 0;
      @(negedge clk);
      chk("R8 not taken", int'(in_ready), 0, 0);
    end
    pull_frame(0);
    in_valid = 0;
    for (int p = 0; p < M; p++) begin
      chk("R8 low", got_lo[p], exp_lo[p], 3);
      chk("R8 high", got_hi[p], exp_hi[p], 3);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_ramp();
    t_impulse();
    t_constant();
    t_extremes();
    t_backpressure();
    t_back_to_back();
    t_ignore_busy();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule